// File: doc/BRIEF.md
# Linked Command List Executor

This block runs a chain of command blocks that software has placed in memory. Each block is a small record. It holds a status halfword, a command halfword and a 32-bit pointer to the next block. A pulse on `start` loads the address of the first block and makes the command unit active. The executor then handles one block at a time. It marks the block busy, reads its command and carries out the opcode. It then writes a completion status, reads the next pointer and decides whether to continue.

Most opcodes only need an outside agent to do the work, for example moving transmit data or copying an address. For these the block issues a one-cycle dispatch strobe and waits for a done pulse. Two opcodes are handled inside the block. Configure loads a clamped number of bytes into an internal settings array and then forces some fixed bits. Link test writes the current link state back into the block. The command word also carries flags: one stops the walk at this block, one suspends the command unit, and one raises a completion event with an interrupt pulse.

Top module: `cmd_list_walker`

## Requirements
- R1: After reset the unit is idle (`cu_state` = 0), `cmd_done_flag` and `irq` are low, no memory request is made and every settings byte is 0.
- R2: Memory uses halfwords at even byte addresses; the byte at the lower address is in bits 15:8. Each block first gets 0x4000 written at its offset 0. When it finishes, offset 0 gets 0xA000 (complete and OK).
- R3: The next pointer is read as a low half at offset 4 and a high half at offset 6. A value of 0 or 0xFFFFFFFF ends the walk, and the unit then returns to idle (`cu_state` = 0).
- R4: The command halfword is at offset 2 and its opcode is bits 2:0. If bit 15 is set, the walk ends after this block whatever the pointer holds.
- R5: If command bit 14 is set, `cu_state` becomes 1 (suspended) after the block and no further memory access takes place. When bits 14 and 15 are both set, suspended takes precedence over idle.
- R6: If command bit 13 is set, `cmd_done_flag` is set and `irq` pulses for one cycle when the block finishes. A block finishing with bit 13 clear clears the flag.
- R7: Opcodes 1, 3 and 4 raise `disp_valid` for one cycle, with the opcode and the block address. The completion write waits for `disp_done`. Opcodes 0, 2, 5, 6 and 7 never dispatch.
- R8: Opcodes 6 and 7 finish with status 0x8000 (complete, OK clear).
- R9: For configure (opcode 2), the byte count is the low nibble of the byte at offset 8, raised to at least 4 and cut to at most CFG_BYTES. That many bytes are loaded, starting at offset 8, into settings bytes 0 and upward. No halfword beyond the last needed byte is read.
- R10: After a configure load, the settings bytes are fixed up as follows. Byte 2 becomes (b & 0x82) | 0x40. Bit 3 of byte 7 is cleared. Byte 10 is raised to at least 5. Byte 12 is masked to 0x40. Byte 13 is ORed with 0x3F.
- R11: Link test (opcode 5) writes a 32-bit value at offset 8: 0x8000 if `link_up` is high, otherwise 0. The low half goes at offset 8 and the high half (0) at offset 10.
- R12: A `start` pulse while the unit is active is ignored.
- R13: Once raised, `mem_req`, `mem_addr` and `mem_we` are held until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `head_addr` |
| head_addr | input | AW | Byte address of the first block |
| link_up | input | 1 | Current link state reported by link test |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the halfword |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| disp_valid | output | 1 | One-cycle dispatch strobe to a handler |
| disp_op | output | 3 | Opcode being dispatched |
| disp_addr | output | AW | Address of the dispatched block |
| disp_done | input | 1 | Handler finished |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| cmd_done_flag | output | 1 | Completion event flag |
| irq | output | 1 | One-cycle interrupt request |
| cfg_bytes | output | 8*CFG_BYTES | Settings array, byte i at bits 8i+7:8i |

## Verification
The end of a block can apply several effects in one cycle. It resolves the end-of-list flag, the suspend flag and the interrupt flag together. The bench provokes this with a single command word that sets bits 15, 14 and 13. It then judges the outcome: the unit must be suspended rather than idle, the flag must be set and exactly one interrupt pulse must have been seen. A second overlap occurs when a new `start` arrives while a dispatch is still waiting for its done pulse. It is judged by checking that the second list's status word is never written.

// File: rtl/cmd_list_walker.sv
module cmd_list_walker #(
  parameter int AW        = 32,
  parameter int CFG_BYTES = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          head_addr,
  input  logic                   link_up,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [15:0]            mem_wdata,
  input  logic [15:0]            mem_rdata,
  input  logic                   mem_ack,
  output logic                   disp_valid,
  output logic [2:0]             disp_op,
  output logic [AW-1:0]          disp_addr,
  input  logic                   disp_done,
  output logic [1:0]             cu_state,
  output logic                   cmd_done_flag,
  output logic                   irq,
  output logic [8*CFG_BYTES-1:0] cfg_bytes
);
  localparam int IW = $clog2(CFG_BYTES + 2);
  localparam logic [AW-1:0] NULL_PTR = '1;
  localparam logic [1:0] CU_IDLE = 2'd0, CU_SUSP = 2'd1, CU_ACT = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_BUSYW, S_CMDR, S_DISP, S_DWAIT, S_CFGR, S_CFGFIX,
    S_LT0, S_LT1, S_STATW, S_LNK0, S_LNK1
  } st_t;

  st_t             st;
  logic [AW-1:0]   ptr;
  logic [15:0]     cmd, lnk_lo, stat;
  logic [IW-1:0]   cfg_idx, cfg_cnt, nib_cnt, cnt_use, idx1;
  logic [7:0]      cfg [CFG_BYTES];
  logic [1:0]      cu;
  logic            flag, irq_r;
  logic [AW-1:0]   nxt;

  assign cu_state      = cu;
  assign cmd_done_flag = flag;
  assign irq           = irq_r;
  assign disp_valid    = (st == S_DISP);
  assign disp_op       = cmd[2:0];
  assign disp_addr     = ptr;
  assign idx1          = cfg_idx + IW'(1);

  always_comb begin
    if (int'(mem_rdata[11:8]) < 4)                nib_cnt = IW'(4);
    else if (int'(mem_rdata[11:8]) > CFG_BYTES)   nib_cnt = IW'(CFG_BYTES);
    else                                          nib_cnt = IW'(mem_rdata[11:8]);
  end
  assign cnt_use = (cfg_idx == '0) ? nib_cnt : cfg_cnt;

  always_comb begin
    nxt = {mem_rdata, lnk_lo};
    if (nxt == '0) nxt = NULL_PTR;
    if (cmd[15])   nxt = NULL_PTR;
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = 16'h0000;
    case (st)
      S_BUSYW: begin mem_we = 1'b1; mem_wdata = 16'h4000; end
      S_CMDR:  mem_addr = ptr + AW'(2);
      S_CFGR:  mem_addr = ptr + AW'(8) + AW'(cfg_idx);
      S_LT0:   begin mem_we = 1'b1; mem_addr = ptr + AW'(8);
                     mem_wdata = link_up ? 16'h8000 : 16'h0000; end
      S_LT1:   begin mem_we = 1'b1; mem_addr = ptr + AW'(10); end
      S_STATW: begin mem_we = 1'b1; mem_wdata = stat; end
      S_LNK0:  mem_addr = ptr + AW'(4);
      S_LNK1:  mem_addr = ptr + AW'(6);
      default: mem_req = 1'b0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < CFG_BYTES; g++) begin : g_flat
      assign cfg_bytes[8*g +: 8] = cfg[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= NULL_PTR;
      cmd     <= '0;
      lnk_lo  <= '0;
      stat    <= '0;
      cfg_idx <= '0;
      cfg_cnt <= '0;
      cu      <= CU_IDLE;
      flag    <= 1'b0;
      irq_r   <= 1'b0;
      for (int i = 0; i < CFG_BYTES; i++) cfg[i] <= 8'h00;
    end else begin
      irq_r <= 1'b0;
      case (st)
        S_IDLE:
          if (start && cu != CU_ACT && head_addr != '0 && head_addr != NULL_PTR) begin
            ptr <= head_addr;
            cu  <= CU_ACT;
            st  <= S_BUSYW;
          end
        S_BUSYW: if (mem_ack) st <= S_CMDR;
        S_CMDR:
          if (mem_ack) begin
            cmd <= mem_rdata;
            case (mem_rdata[2:0])
              3'd0:       begin stat <= 16'hA000; st <= S_STATW; end
              3'd2:       begin cfg_idx <= '0; st <= S_CFGR; end
              3'd5:       st <= S_LT0;
              3'd6, 3'd7: begin stat <= 16'h8000; st <= S_STATW; end
              default:    st <= S_DISP;
            endcase
          end
        S_DISP:  st <= S_DWAIT;
        S_DWAIT: if (disp_done) begin stat <= 16'hA000; st <= S_STATW; end
        S_CFGR:
          if (mem_ack) begin
            cfg_cnt <= cnt_use;
            if (cfg_idx < cnt_use) cfg[cfg_idx] <= mem_rdata[15:8];
            if (idx1 < cnt_use)    cfg[idx1]    <= mem_rdata[7:0];
            cfg_idx <= cfg_idx + IW'(2);
            if (int'(cfg_idx) + 2 >= int'(cnt_use)) st <= S_CFGFIX;
          end
        S_CFGFIX: begin
          cfg[2]  <= (cfg[2] & 8'h82) | 8'h40;
          cfg[7]  <= cfg[7] & 8'hF7;
          if (cfg[10] < 8'd5) cfg[10] <= 8'd5;
          cfg[12] <= cfg[12] & 8'h40;
          cfg[13] <= cfg[13] | 8'h3F;
          stat    <= 16'hA000;
          st      <= S_STATW;
        end
        S_LT0:   if (mem_ack) st <= S_LT1;
        S_LT1:   if (mem_ack) begin stat <= 16'hA000; st <= S_STATW; end
        S_STATW: if (mem_ack) st <= S_LNK0;
        S_LNK0:  if (mem_ack) begin lnk_lo <= mem_rdata; st <= S_LNK1; end
        S_LNK1:
          if (mem_ack) begin
            ptr   <= nxt;
            flag  <= cmd[13];
            irq_r <= cmd[13];
            if (cmd[14]) begin
              cu <= CU_SUSP; st <= S_IDLE;
            end else if (nxt == NULL_PTR) begin
              cu <= CU_IDLE; st <= S_IDLE;
            end else begin
              st <= S_BUSYW;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_done_flag); // R6
  AST_DISP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid); // R7
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_state == CU_SUSP) |-> (!mem_req && !disp_valid)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_state == CU_IDLE) |-> !mem_req); // R3
endmodule

// File: tb/cmd_list_walker_test.sv
module cmd_list_walker_test;
  logic        clk = 0, rst_n = 0, start = 0, link_up = 1;
  logic [31:0] head_addr = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic        disp_valid, disp_done = 0;
  logic [2:0]  disp_op;
  logic [31:0] disp_addr;
  logic [1:0]  cu_state;
  logic        cmd_done_flag, irq;
  logic [111:0] cfg_bytes;

  cmd_list_walker uut (.*);

  always #10 clk = ~clk;

  logic [15:0] mem [256];
  logic        busy_seen [256];
  int lat = 0, wc = 0, max_rd = 0, disp_delay = 2, dtmr = 0, disp_cnt = 0;
  int irq_cnt = 0, hold_bad = 0, total = 0, bad = 0;
  logic dpend = 0;
  logic [2:0]  last_op;
  logic [31:0] last_addr;
  logic preq = 0, pack = 0;
  logic [31:0] paddr = 0;

  always @(posedge clk) begin
    mem_ack <= 0;
    if (mem_req && !mem_ack) begin
      if (wc >= lat) begin
        wc <= 0;
        mem_ack <= 1;
        if (mem_we) begin
          mem[mem_addr[8:1]] <= mem_wdata;
          if (mem_wdata == 16'h4000) busy_seen[mem_addr[8:1]] <= 1;
        end else begin
          mem_rdata <= mem[mem_addr[8:1]];
          if (int'(mem_addr) > max_rd) max_rd <= int'(mem_addr);
        end
      end else wc <= wc + 1;
    end
  end

  always @(posedge clk) begin
    disp_done <= 0;
    if (dpend) begin
      if (dtmr == 0) begin disp_done <= 1; dpend <= 0; end
      else dtmr <= dtmr - 1;
    end
    if (disp_valid) begin
      dpend <= 1; dtmr <= disp_delay; disp_cnt <= disp_cnt + 1;
      last_op <= disp_op; last_addr <= disp_addr;
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (preq && !pack && (!mem_req || mem_addr != paddr)) hold_bad++;
    preq = mem_req; pack = mem_ack; paddr = mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 256; i++) begin mem[i] = 0; busy_seen[i] = 0; end
    max_rd = 0; disp_cnt = 0; irq_cnt = 0;
  endtask

  task automatic blk(input int a, input logic [15:0] c, input logic [31:0] lk);
    mem[(a >> 1)]     = 16'h0000;
    mem[(a >> 1) + 1] = c;
    mem[(a >> 1) + 2] = lk[15:0];
    mem[(a >> 1) + 3] = lk[31:16];
  endtask

  task automatic run(input logic [31:0] h);
    @(negedge clk); head_addr = h; start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 5000 && cu_state == 2'd2; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] cb(input int i);
    return cfg_bytes[8*i +: 8];
  endfunction

  localparam logic [47:0] VEC [7] = '{
    {16'h8000, 16'hA000, 16'd0},
    {16'h8001, 16'hA000, 16'd1},
    {16'h8003, 16'hA000, 16'd1},
    {16'h8004, 16'hA000, 16'd1},
    {16'h8005, 16'hA000, 16'd0},
    {16'h8006, 16'h8000, 16'd0},
    {16'h8007, 16'h8000, 16'd0}
  };

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk("R1 cu_state", {30'd0, cu_state}, 0);
    chk("R1 flag/irq", {30'd0, cmd_done_flag, irq}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 cfg", {31'd0, cfg_bytes == '0}, 1);
    rst_n = 1;

    for (int v = 0; v < 7; v++) begin
      clr();
      blk(32'h40, VEC[v][47:32], 32'h80);
      blk(32'h80, 16'h8000, 32'h0);
      run(32'h40);
      chk("R2 R8 final status", {16'd0, mem[8'h20]}, {16'd0, VEC[v][31:16]});
      chk("R2 busy write", {31'd0, busy_seen[8'h20]}, 1);
      chk("R4 end-of-list stops", {16'd0, mem[8'h40]}, 0);
      chk("R7 dispatch count", disp_cnt, {16'd0, VEC[v][15:0]});
      if (VEC[v][15:0] != 0) begin
        chk("R7 disp op", {29'd0, last_op}, {29'd0, VEC[v][34:32]});
        chk("R7 disp addr", last_addr, 32'h40);
      end
      chk("R3 idle after", {30'd0, cu_state}, 0);
    end

    clr();
    blk(32'h40, 16'h0000, 32'h80);
    blk(32'h80, 16'h2000, 32'hC0);
    blk(32'hC0, 16'h0000, 32'h0);
    run(32'h40);
    chk("R3 chain blk3", {16'd0, mem[8'h60]}, 32'hA000);
    chk("R3 chain blk2", {16'd0, mem[8'h40]}, 32'hA000);
    chk("R6 flag cleared by last", {31'd0, cmd_done_flag}, 0);
    chk("R6 one irq", irq_cnt, 1);

    clr();
    blk(32'h40, 16'h2000, 32'hFFFFFFFF);
    blk(32'h80, 16'h0000, 32'h0);
    run(32'h40);
    chk("R3 null link stops", {16'd0, mem[8'h40]}, 0);
    chk("R6 flag set", {31'd0, cmd_done_flag}, 1);
    chk("R3 idle", {30'd0, cu_state}, 0);

    clr();
    blk(32'h40, 16'h4000, 32'h80);
    blk(32'h80, 16'h8000, 32'h0);
    run(32'h40);
    chk("R5 suspended", {30'd0, cu_state}, 1);
    chk("R5 next untouched", {16'd0, mem[8'h40]}, 0);

    clr();
    blk(32'h40, 16'hE000, 32'h80);
    run(32'h40);
    chk("R5 susp beats eol", {30'd0, cu_state}, 1);
    chk("R6 flag with susp", {31'd0, cmd_done_flag}, 1);
    chk("R6 irq with susp", irq_cnt, 1);

    lat = 2;
    clr();
    blk(32'h40, 16'h8002, 32'h0);
    mem[8'h24] = 16'h0211; mem[8'h25] = 16'hFF33; mem[8'h26] = 16'h5566;
    run(32'h40);
    chk("R9 min count reads", max_rd, 32'h4A);
    chk("R9 byte3", {24'd0, cb(3)}, 32'h33);
    chk("R9 byte4 unloaded", {24'd0, cb(4)}, 0);
    chk("R10 byte2", {24'd0, cb(2)}, 32'hC2);
    chk("R10 byte10 raised", {24'd0, cb(10)}, 5);
    chk("R10 byte13", {24'd0, cb(13)}, 32'h3F);
    chk("R2 config status", {16'd0, mem[8'h20]}, 32'hA000);

    clr();
    blk(32'h40, 16'h8002, 32'h0);
    mem[8'h24] = 16'h8F01; mem[8'h25] = 16'h3C03; mem[8'h26] = 16'h0405;
    mem[8'h27] = 16'h06FF; mem[8'h28] = 16'h0809; mem[8'h29] = 16'h09AB;
    mem[8'h2A] = 16'hFF00; mem[8'h2B] = 16'h7777;
    run(32'h40);
    chk("R9 max count reads", max_rd, 32'h54);
    chk("R9 byte0", {24'd0, cb(0)}, 32'h8F);
    chk("R9 byte11", {24'd0, cb(11)}, 32'hAB);
    chk("R10 byte2 masked", {24'd0, cb(2)}, 32'h40);
    chk("R10 byte7", {24'd0, cb(7)}, 32'hF7);
    chk("R10 byte10 kept", {24'd0, cb(10)}, 9);
    chk("R10 byte12", {24'd0, cb(12)}, 32'h40);
    chk("R10 byte13 or", {24'd0, cb(13)}, 32'h3F);
    chk("R13 request held", hold_bad, 0);
    lat = 0;

    clr();
    blk(32'h40, 16'h8005, 32'h0);
    mem[8'h24] = 16'h1234; mem[8'h25] = 16'h5678;
    run(32'h40);
    chk("R11 link up lo", {16'd0, mem[8'h24]}, 32'h8000);
    chk("R11 link up hi", {16'd0, mem[8'h25]}, 0);
    link_up = 0;
    blk(32'h40, 16'h8005, 32'h0);
    run(32'h40);
    chk("R11 link down", {16'd0, mem[8'h24]}, 0);
    link_up = 1;

    clr();
    disp_delay = 30;
    blk(32'h40, 16'h8004, 32'h0);
    blk(32'h100, 16'h8000, 32'h0);
    @(negedge clk); head_addr = 32'h40; start = 1;
    @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    head_addr = 32'h100; start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 5000 && cu_state == 2'd2; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R12 second list untouched", {16'd0, mem[8'h80]}, 0);
    chk("R12 first list done", {16'd0, mem[8'h20]}, 32'hA000);
    chk("R7 waited for done", disp_cnt, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule